// File: doc/BRIEF.md
# Speculative Store Buffer with Load Forwarding

This block holds the address and data of stores that have executed but not yet committed, so that the data cache is written only once a store is known to be architecturally valid. Each slot keeps an occupied flag, a speculative flag, a word address, one word of data and the store's instruction age. Slots are allocated at the tail of a circular queue in program order. They leave from the head in the same order, one per cycle, once they are no longer speculative and the cache accepts them.

A commit port names a store by its age and clears that store's speculative flag. An abort port takes an age boundary and, in a single edge, discards every speculative store younger than that boundary, without writing memory. A combinational load port compares a load's word address and age with the held stores. It returns the data of the youngest matching store that is older than the load, which then takes priority over the cache. If no such store exists it reports a miss, and the cache value is used.

Top module: `spec_store_buffer`

## Requirements
- R1: After synchronous reset the buffer is empty: `st_ready` is 1, `dr_valid` is 0 and `ld_hit` is 0.
- R2: A store is taken on a clock edge where `st_valid` and `st_ready` are both 1. It occupies one slot as speculative, holding `st_addr`, `st_data` and `st_age`.
- R3: `st_ready` is 0 while DEPTH slots are occupied, and also in any cycle where `ab_valid` is 1.
- R4: `cm_valid` with `cm_age` clears the speculative flag of the occupied store whose age equals `cm_age`. An age that matches no speculative store changes nothing.
- R5: `dr_valid` is 1 exactly when the oldest held store is not speculative, and `dr_addr`/`dr_data` then show that store. It leaves the buffer on an edge with `dr_ready` at 1, and stores leave one per cycle in the order they were taken. A speculative oldest store blocks everything behind it.
- R6: On an edge with `ab_valid` at 1, every speculative store strictly younger than `ab_age` is discarded and its slot freed. Committed stores, and stores of age equal to or older than `ab_age`, are kept.
- R7: `ld_hit` is 1 in the same cycle when some held store has a word address equal to `ld_addr` and an age strictly older than `ld_age`. Stores of equal or younger age are ignored. Otherwise `ld_hit` is 0 and the cache value applies.
- R8: When several held stores qualify under R7, `ld_data` is the data of the youngest of them.
- R9: Ages wrap modulo 2^6. Age a is older than age b when bit 5 of (a - b) mod 64 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Executed store presented |
| st_ready | output | 1 | A store can be taken this cycle |
| st_addr | input | 30 | Store word address |
| st_data | input | 32 | Store data word |
| st_age | input | 6 | Store instruction age |
| cm_valid | input | 1 | Commit request |
| cm_age | input | 6 | Age of the committing store |
| ab_valid | input | 1 | Abort request |
| ab_age | input | 6 | Abort boundary age |
| ld_addr | input | 30 | Load word address |
| ld_age | input | 6 | Load instruction age |
| ld_hit | output | 1 | An older matching store exists |
| ld_data | output | 32 | Forwarded data |
| dr_valid | output | 1 | Committed store offered to cache |
| dr_ready | input | 1 | Cache accepts the offered store |
| dr_addr | output | 30 | Drained word address |
| dr_data | output | 32 | Drained data word |

## Verification
Directed sequences come first. Three stores to one address, probed with loads of differing age, tell youngest-older selection apart from plain first-match and from forwarding off equal-age stores. An abort whose boundary sits between stores shows that the younger stores are dropped while the older one keeps forwarding. A filled buffer shows the back-pressure. A commit naming a non-existent age confirms that nothing drains. The random phase mixes stores, in-order commits, aborts at random speculative boundaries, and random cache acceptance over a four-address pool. Ages wrap many times in this phase, so the modular age compare is exercised together with drain ordering under stall.

// File: rtl/ssb_pkg.sv
package ssb_pkg;

    localparam int SSB_ADDR_W = 30;
    localparam int SSB_DATA_W = 32;
    localparam int SSB_AGE_W  = 6;

    typedef logic [SSB_ADDR_W-1:0] addr_t;
    typedef logic [SSB_DATA_W-1:0] data_t;
    typedef logic [SSB_AGE_W-1:0]  age_t;

    typedef struct packed {
        logic  vld;
        logic  spec;
        addr_t addr;
        data_t data;
        age_t  age;
    } ssb_entry_t;

    // a is older than b under modular age arithmetic
    function automatic logic age_older(input age_t a, input age_t b);
        age_t d;
        d = a - b;
        return d[SSB_AGE_W-1];
    endfunction

endpackage

// File: rtl/ssb_queue_ctl.sv
module ssb_queue_ctl #(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             pop,
    input  logic             abort,
    input  logic [CNT_W-1:0] keep_cnt,
    output logic [IDX_W-1:0] head,
    output logic [IDX_W-1:0] tail,
    output logic             full,
    output logic             empty
);

    logic [IDX_W-1:0] head_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (pop)
                head_q <= head_q + IDX_W'(1);
            if (abort)
                cnt_q <= keep_cnt - CNT_W'(pop);
            else
                cnt_q <= cnt_q + CNT_W'(push) - CNT_W'(pop);
        end
    end

    assign head  = head_q;
    assign tail  = head_q + IDX_W'(cnt_q);
    assign full  = (cnt_q == CNT_W'(DEPTH));
    assign empty = (cnt_q == '0);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        int'(cnt_q) <= DEPTH); // R3
    AST_POP_COUNT: assert property (@(posedge clk) disable iff (rst)
        pop && !abort |=> int'(cnt_q) == int'($past(cnt_q)) - 1 + int'($past(push))); // R5

endmodule

// File: rtl/ssb_forward.sv
module ssb_forward
    import ssb_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  ssb_entry_t ent [DEPTH],
    input  addr_t      ld_addr,
    input  age_t       ld_age,
    output logic       hit,
    output data_t      data
);

    // Youngest qualifying store wins: pick by age, not by slot index
    always_comb begin
        age_t best_age;
        hit      = 1'b0;
        data     = '0;
        best_age = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (ent[i].vld && ent[i].addr == ld_addr &&
                age_older(ent[i].age, ld_age) &&
                (!hit || age_older(best_age, ent[i].age))) begin
                hit      = 1'b1;
                data     = ent[i].data;
                best_age = ent[i].age;
            end
        end
    end

endmodule

// File: rtl/spec_store_buffer.sv
module spec_store_buffer
    import ssb_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  st_valid,
    output logic                  st_ready,
    input  logic [SSB_ADDR_W-1:0] st_addr,
    input  logic [SSB_DATA_W-1:0] st_data,
    input  logic [SSB_AGE_W-1:0]  st_age,
    input  logic                  cm_valid,
    input  logic [SSB_AGE_W-1:0]  cm_age,
    input  logic                  ab_valid,
    input  logic [SSB_AGE_W-1:0]  ab_age,
    input  logic [SSB_ADDR_W-1:0] ld_addr,
    input  logic [SSB_AGE_W-1:0]  ld_age,
    output logic                  ld_hit,
    output logic [SSB_DATA_W-1:0] ld_data,
    output logic                  dr_valid,
    input  logic                  dr_ready,
    output logic [SSB_ADDR_W-1:0] dr_addr,
    output logic [SSB_DATA_W-1:0] dr_data
);

    ssb_entry_t       ent_q [DEPTH];
    logic [DEPTH-1:0] kill;
    logic [DEPTH-1:0] cm_hit;
    logic [CNT_W-1:0] keep_cnt;
    logic [IDX_W-1:0] head, tail;
    logic             full, empty, push, pop;

    assign st_ready = !full && !ab_valid;
    assign push     = st_valid && st_ready;
    assign dr_valid = ent_q[head].vld && !ent_q[head].spec;
    assign dr_addr  = ent_q[head].addr;
    assign dr_data  = ent_q[head].data;
    assign pop      = dr_valid && dr_ready;

    always_comb begin
        keep_cnt = '0;
        for (int i = 0; i < DEPTH; i++)
            keep_cnt = keep_cnt + CNT_W'(ent_q[i].vld && !kill[i]);
    end

    ssb_queue_ctl #(.DEPTH(DEPTH)) u_ctl (
        .clk      (clk),
        .rst      (rst),
        .push     (push),
        .pop      (pop),
        .abort    (ab_valid),
        .keep_cnt (keep_cnt),
        .head     (head),
        .tail     (tail),
        .full     (full),
        .empty    (empty)
    );

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        assign kill[i]   = ab_valid && ent_q[i].vld && ent_q[i].spec &&
                           age_older(ab_age, ent_q[i].age);
        assign cm_hit[i] = cm_valid && ent_q[i].vld && ent_q[i].spec &&
                           ent_q[i].age == cm_age;

        always_ff @(posedge clk) begin
            if (rst) begin
                ent_q[i].vld  <= 1'b0;
                ent_q[i].spec <= 1'b0;
                ent_q[i].addr <= '0;
                ent_q[i].data <= '0;
                ent_q[i].age  <= '0;
            end else begin
                if (cm_hit[i])
                    ent_q[i].spec <= 1'b0;
                if ((pop && head == IDX_W'(i)) || kill[i])
                    ent_q[i].vld <= 1'b0;
                if (push && tail == IDX_W'(i)) begin
                    ent_q[i].vld  <= 1'b1;
                    ent_q[i].spec <= 1'b1;
                    ent_q[i].addr <= st_addr;
                    ent_q[i].data <= st_data;
                    ent_q[i].age  <= st_age;
                end
            end
        end

        AST_COMMIT_CLEARS: assert property (@(posedge clk) disable iff (rst)
            cm_hit[i] && !kill[i] |=> !ent_q[i].spec); // R4
        AST_ABORT_FREES: assert property (@(posedge clk) disable iff (rst)
            kill[i] |=> !ent_q[i].vld); // R6
    end

    ssb_forward #(.DEPTH(DEPTH)) u_fwd (
        .ent     (ent_q),
        .ld_addr (ld_addr),
        .ld_age  (ld_age),
        .hit     (ld_hit),
        .data    (ld_data)
    );

    AST_ABORT_STALL: assert property (@(posedge clk) disable iff (rst)
        ab_valid |-> !st_ready); // R3
    AST_DRAIN_HOLD: assert property (@(posedge clk) disable iff (rst)
        dr_valid && !dr_ready |=> dr_valid && $stable(dr_addr) && $stable(dr_data)); // R5
    AST_HIT_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
        ld_hit |-> !empty); // R7

endmodule

// File: tb/test_spec_store_buffer.sv
module test_spec_store_buffer;

    localparam int D = 8;

    logic        clk = 1'b0;
    logic        rst;
    logic        st_valid, st_ready, cm_valid, ab_valid, ld_hit, dr_valid, dr_ready;
    logic [29:0] st_addr, ld_addr, dr_addr;
    logic [31:0] st_data, ld_data, dr_data;
    logic [5:0]  st_age, cm_age, ab_age, ld_age;

    int errors = 0;
    int checks = 0;

    typedef struct {
        logic [29:0] a;
        logic [31:0] d;
        logic [5:0]  g;
        bit          s;
    } ment_t;
    ment_t mq[$];

    logic [5:0] next_age = 6'd0;
    bit obs_hit, obs_drv, obs_rdy;
    logic [31:0] obs_data;

    always #4 clk = ~clk;

    spec_store_buffer #(.DEPTH(D)) i_spec_store_buffer (
        .clk(clk), .rst(rst),
        .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr),
        .st_data(st_data), .st_age(st_age),
        .cm_valid(cm_valid), .cm_age(cm_age),
        .ab_valid(ab_valid), .ab_age(ab_age),
        .ld_addr(ld_addr), .ld_age(ld_age), .ld_hit(ld_hit), .ld_data(ld_data),
        .dr_valid(dr_valid), .dr_ready(dr_ready), .dr_addr(dr_addr), .dr_data(dr_data)
    );

    function automatic bit older(input logic [5:0] a, input logic [5:0] b); // R9
        logic [5:0] d;
        d = a - b;
        return d[5];
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One cycle: drive after negedge, check combinational outputs, update model at posedge
    task automatic step(input bit sv, input logic [29:0] sa, input logic [31:0] sd,
                        input bit cv, input logic [5:0] ca,
                        input bit av, input logic [5:0] aa,
                        input logic [29:0] la, input logic [5:0] lg, input bit dr);
        bit e_rdy, e_drv, e_hit, found;
        logic [31:0] e_data;
        logic [5:0] best;
        int nmatch;
        st_valid = sv; st_addr = sa; st_data = sd; st_age = next_age;
        cm_valid = cv; cm_age = ca; ab_valid = av; ab_age = aa;
        ld_addr = la; ld_age = lg; dr_ready = dr;
        #1;
        e_rdy = (mq.size() < D) && !av;
        chk("R3 st_ready", 64'(st_ready), 64'(e_rdy));
        e_drv = (mq.size() > 0) && !mq[0].s;
        chk("R5 dr_valid", 64'(dr_valid), 64'(e_drv));
        if (e_drv) begin
            chk("R5 dr_addr", 64'(dr_addr), 64'(mq[0].a));
            chk("R5 dr_data", 64'(dr_data), 64'(mq[0].d));
        end
        found = 0; e_data = '0; best = '0; nmatch = 0;
        foreach (mq[k]) begin
            if (mq[k].a == la && older(mq[k].g, lg)) begin
                nmatch++;
                if (!found || older(best, mq[k].g)) begin
                    found = 1; best = mq[k].g; e_data = mq[k].d;
                end
            end
        end
        e_hit = found;
        chk("R7 R9 ld_hit", 64'(ld_hit), 64'(e_hit));
        if (e_hit) chk(nmatch > 1 ? "R8 ld_data" : "R7 ld_data", 64'(ld_data), 64'(e_data));
        obs_hit = ld_hit; obs_data = ld_data; obs_drv = dr_valid; obs_rdy = st_ready;
        @(posedge clk);
        if (e_drv && dr) void'(mq.pop_front());
        if (cv) foreach (mq[k]) if (mq[k].s && mq[k].g == ca) mq[k].s = 0;
        if (av) for (int k = mq.size() - 1; k >= 0; k--)
            if (mq[k].s && older(aa, mq[k].g)) mq.delete(k);
        if (sv && e_rdy) begin
            mq.push_back('{a: sa, d: sd, g: next_age, s: 1'b1});
            next_age = next_age + 6'd1;
        end
        @(negedge clk);
    endtask

    task automatic idle(input logic [29:0] la, input logic [5:0] lg, input bit dr);
        step(0, '0, '0, 0, '0, 0, '0, la, lg, dr);
    endtask

    initial begin : watchdog
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic [5:0] a0, a2;
        void'($urandom(32'd4711));
        rst = 1'b1;
        st_valid = 0; st_addr = '0; st_data = '0; st_age = '0;
        cm_valid = 0; cm_age = '0; ab_valid = 0; ab_age = '0;
        ld_addr = '0; ld_age = '0; dr_ready = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 st_ready", 64'(st_ready), 64'd1);
        chk("R1 dr_valid", 64'(dr_valid), 64'd0);
        chk("R1 ld_hit", 64'(ld_hit), 64'd0);
        @(negedge clk);

        // R2 R8: three stores to one word, selection by age
        a0 = next_age;
        step(1, 30'h40, 32'h11, 0, '0, 0, '0, 30'h40, a0, 0);
        step(1, 30'h40, 32'h22, 0, '0, 0, '0, 30'h40, a0, 0);
        step(1, 30'h40, 32'h33, 0, '0, 0, '0, 30'h40, a0, 0);
        a2 = a0 + 6'd2;
        idle(30'h40, a2, 0);
        chk("R8 youngest older", {obs_hit, obs_data}, {1'b1, 32'h22});
        idle(30'h40, a0, 0);
        chk("R7 equal age ignored", 64'(obs_hit), 64'd0);
        idle(30'h40, a2 + 6'd1, 0);
        chk("R2 R8 newest stored", {obs_hit, obs_data}, {1'b1, 32'h33});

        // R4 commit oldest, R6 abort above it
        step(0, '0, '0, 1, a0, 0, '0, 30'h40, a0, 0);
        step(0, '0, '0, 0, '0, 1, a0, 30'h40, a0, 0);
        chk("R4 committed drains", 64'(obs_drv), 64'd1);
        idle(30'h40, next_age, 0);
        chk("R6 younger aborted", {obs_hit, obs_data}, {1'b1, 32'h11});
        idle(30'h40, next_age, 1);
        idle(30'h40, next_age, 0);
        chk("R5 drained gone", 64'(obs_hit), 64'd0);

        // R4 commit of unknown age leaves store speculative
        step(1, 30'h41, 32'h44, 0, '0, 0, '0, '0, '0, 1);
        step(0, '0, '0, 1, next_age + 6'd10, 0, '0, '0, '0, 1);
        idle('0, '0, 1);
        chk("R4 bogus commit", 64'(obs_drv), 64'd0);

        // R3 fill, then R6 abort everything
        while (mq.size() < D) step(1, 30'h50, $urandom, 0, '0, 0, '0, '0, '0, 0);
        idle('0, '0, 0);
        chk("R3 full stall", 64'(obs_rdy), 64'd0);
        step(0, '0, '0, 0, '0, 1, mq[0].g - 6'd1, '0, '0, 0);
        idle(30'h50, next_age, 0);
        chk("R6 all freed", {obs_rdy, obs_hit}, {1'b1, 1'b0});

        // Random phase
        for (int n = 0; n < 4000; n++) begin
            bit sv, cv, av, dr;
            logic [5:0] ca, aa, lg;
            int nspec, first_spec;
            nspec = 0; first_spec = -1;
            foreach (mq[k]) if (mq[k].s) begin
                nspec++;
                if (first_spec < 0) first_spec = k;
            end
            sv = ($urandom % 2) == 0;
            cv = ($urandom % 10) < 3;
            ca = (first_spec >= 0 && ($urandom % 8) != 0) ? mq[first_spec].g : next_age + 6'd12;
            av = ($urandom % 14) == 0;
            aa = (nspec > 0) ? mq[first_spec + ($urandom % nspec)].g : next_age - 6'd1;
            dr = ($urandom % 10) < 6;
            lg = (mq.size() > 0 && ($urandom % 2) == 0) ? mq[$urandom % mq.size()].g : next_age;
            step(sv, 30'h60 + 30'($urandom % 4), $urandom, cv, ca, av, aa,
                 30'h60 + 30'($urandom % 4), lg, dr);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule